// File: doc/BRIEF.md
# Three-Port Programmable Parallel I/O

This block is a bus-attached parallel I/O peripheral. It has three 8-bit ports. Ports A and B are each one direction group. Port C is split into a lower nibble and an upper nibble, and each nibble is its own direction group. A host reaches the block through an 8-bit data bus. The bus uses an active-low chip select, active-low read and write strobes and a 2-bit register address. The host can write a configuration word that sets the direction of each group. It can also send a one-bit command that sets or clears a single port C bit.

Only the basic mode is implemented. Output data is kept in per-port latches, and input data is taken straight from the pins whenever a read happens. The host may write the strobed and bidirectional mode codes. They are stored and read back, but the ports still behave as in basic mode. Pads are modelled as separate pin-in, pin-out and output-enable vectors, and the data bus is modelled as separate in, out and drive-enable signals.

Writes take effect on the rising clock edge while chip select and the write strobe are both low. Reads are combinational and last while chip select and the read strobe are both low.

Top module: `triport_pio`

## Requirements
- R1: Register select: `sel` 00 is port A, 01 is port B, 10 is port C and 11 is the control register. No write has any effect unless `cs_n` is low. `bus_oe` is high only while `cs_n` and `rd_n` are both low, and `bus_out` is 0 otherwise.
- R2: A control write with bit 7 = 1 is a configuration word. Its fields are: bit 0 is the port C lower nibble direction, bit 1 is the port B direction, bit 2 is the group B mode, bit 3 is the port C upper nibble direction, bit 4 is the port A direction and bits 6:5 are the group A mode. For each direction bit, 1 means input and 0 means output.
- R3: Every bit of a group's output-enable is 1 when that group is configured as output, and every bit is 0 when it is configured as input.
- R4: A read of a group configured as input returns the pin values at the time of the read, with no latching.
- R5: A read of a group configured as output returns its latched value. The `*_out` pins always carry the latch.
- R6: A write to a port address loads that port's 8-bit latch on the write edge. Without a write, the latch holds its value.
- R7: A control write with bit 7 = 0 is a bit command. Bits 3:1 select the port C bit and bit 0 gives its new value. All other port C bits and the configuration stay unchanged.
- R8: A configuration word clears all output latches.
- R9: Reset makes every group an input, sets both modes to 0 and clears all latches. A control read then returns 0x9B.
- R10: A control read returns {1, group A mode[1:0], A dir, C upper dir, group B mode, B dir, C lower dir}. Modes 1 and 2 are stored but behave as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| sel | input | 2 | Register select |
| bus_in | input | 8 | Write data from host |
| bus_out | output | 8 | Read data to host |
| bus_oe | output | 1 | Host data bus drive enable |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A pin output |
| pa_oe | output | 8 | Port A output enable |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B pin output |
| pb_oe | output | 8 | Port B output enable |
| pc_in | input | 8 | Port C pin input |
| pc_out | output | 8 | Port C pin output |
| pc_oe | output | 8 | Port C output enable (per nibble) |

## Verification
Assertions check the following on every cycle:
- the output-enables follow each configuration word;
- a configuration word clears every latch;
- a bit command changes only the addressed port C bit, to the commanded value;
- latches hold when nothing is written;
- input groups return their pins on a read;
- the bus stays undriven outside a read.

Some behaviours can only be shown by the bench scenarios:
- the read-back encoding of the control register, including stored mode codes that have no effect;
- the reset value;
- mixed nibble directions within one port C read;
- the fact that a write with chip select high leaves all state untouched.

// File: rtl/triport_pio_pkg.sv
package triport_pio_pkg;

    localparam int PORT_W = 8;
    localparam int NIB_W  = PORT_W / 2;
    localparam int IDX_W  = $clog2(PORT_W);

    typedef enum logic [1:0] {
        SEL_PA   = 2'b00,
        SEL_PB   = 2'b01,
        SEL_PC   = 2'b10,
        SEL_CTRL = 2'b11
    } sel_e;

    // Packed in control read-back order, bits 6:0
    typedef struct packed {
        logic [1:0] mode_a;
        logic       dir_a;
        logic       dir_ch;
        logic       mode_b;
        logic       dir_b;
        logic       dir_cl;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{mode_a: 2'b00, dir_a: 1'b1, dir_ch: 1'b1,
                                   mode_b: 1'b0, dir_b: 1'b1, dir_cl: 1'b1};

    function automatic logic [PORT_W-1:0] bit_mask(input logic [IDX_W-1:0] idx);
        logic [PORT_W-1:0] m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/triport_pio_ctrl.sv
module triport_pio_ctrl
    import triport_pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_act,
    input  logic [1:0]        sel,
    input  logic [PORT_W-1:0] wdata,
    output cfg_t              cfg,
    output logic              def_wr,
    output logic              cmd_wr
);
    logic ctrl_wr;

    assign ctrl_wr = wr_act && (sel_e'(sel) == SEL_CTRL);
    assign def_wr  = ctrl_wr && wdata[PORT_W-1];
    assign cmd_wr  = ctrl_wr && !wdata[PORT_W-1];

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= CFG_RESET;
        else if (def_wr)
            cfg <= cfg_t'(wdata[PORT_W-2:0]);
    end

    // A bit command must leave the configuration alone
    AST_CMD_KEEPS_CFG: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> $stable(cfg)) else $error("cfg changed by bit command"); // R7

endmodule

// File: rtl/triport_pio_lane.sv
module triport_pio_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic [W-1:0] wr_mask,
    input  logic [W-1:0] wr_data,
    input  logic         dir_in,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] rd_data
);
    logic [W-1:0] latch_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || clear)
                latch_q[i] <= 1'b0;
            else if (wr_mask[i])
                latch_q[i] <= wr_data[i];
        end
    end

    assign pin_out = latch_q;
    assign pin_oe  = {W{~dir_in}};
    assign rd_data = dir_in ? pin_in : latch_q;

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_mask == '0 && !clear) |=> $stable(pin_out)) else $error("latch drift"); // R6

endmodule

// File: rtl/triport_pio.sv
module triport_pio
    import triport_pio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic [1:0]  sel,
    input  logic [7:0]  bus_in,
    output logic [7:0]  bus_out,
    output logic        bus_oe,
    input  logic [7:0]  pa_in,
    output logic [7:0]  pa_out,
    output logic [7:0]  pa_oe,
    input  logic [7:0]  pb_in,
    output logic [7:0]  pb_out,
    output logic [7:0]  pb_oe,
    input  logic [7:0]  pc_in,
    output logic [7:0]  pc_out,
    output logic [7:0]  pc_oe
);
    logic              wr_act, rd_act, def_wr, cmd_wr;
    cfg_t              cfg;
    logic [PORT_W-1:0] mask_a, mask_b, mask_c, data_c, cmd_mask;
    logic [PORT_W-1:0] rd_a, rd_b, rd_c;

    assign wr_act = !cs_n && !wr_n;
    assign rd_act = !cs_n && !rd_n;

    triport_pio_ctrl u_ctrl (
        .clk(clk), .rst(rst), .wr_act(wr_act), .sel(sel), .wdata(bus_in),
        .cfg(cfg), .def_wr(def_wr), .cmd_wr(cmd_wr)
    );

    assign cmd_mask = bit_mask(bus_in[IDX_W:1]);

    always_comb begin
        mask_a = '0;
        mask_b = '0;
        mask_c = '0;
        data_c = bus_in;
        if (wr_act) begin
            unique case (sel_e'(sel))
                SEL_PA:   mask_a = '1;
                SEL_PB:   mask_b = '1;
                SEL_PC:   mask_c = '1;
                SEL_CTRL: if (cmd_wr) begin
                    mask_c = cmd_mask;
                    data_c = {PORT_W{bus_in[0]}};
                end
            endcase
        end
    end

    triport_pio_lane #(.W(PORT_W)) u_lane_a (
        .clk(clk), .rst(rst), .clear(def_wr), .wr_mask(mask_a), .wr_data(bus_in),
        .dir_in(cfg.dir_a), .pin_in(pa_in), .pin_out(pa_out), .pin_oe(pa_oe), .rd_data(rd_a)
    );

    triport_pio_lane #(.W(PORT_W)) u_lane_b (
        .clk(clk), .rst(rst), .clear(def_wr), .wr_mask(mask_b), .wr_data(bus_in),
        .dir_in(cfg.dir_b), .pin_in(pb_in), .pin_out(pb_out), .pin_oe(pb_oe), .rd_data(rd_b)
    );

    // Port C: one lane per nibble, each with its own direction
    for (genvar n = 0; n < 2; n++) begin : g_pc
        triport_pio_lane #(.W(NIB_W)) u_lane_c (
            .clk(clk), .rst(rst), .clear(def_wr),
            .wr_mask(mask_c[n*NIB_W +: NIB_W]), .wr_data(data_c[n*NIB_W +: NIB_W]),
            .dir_in((n == 0) ? cfg.dir_cl : cfg.dir_ch),
            .pin_in(pc_in[n*NIB_W +: NIB_W]), .pin_out(pc_out[n*NIB_W +: NIB_W]),
            .pin_oe(pc_oe[n*NIB_W +: NIB_W]), .rd_data(rd_c[n*NIB_W +: NIB_W])
        );
    end

    always_comb begin
        bus_out = '0;
        if (rd_act) begin
            unique case (sel_e'(sel))
                SEL_PA:   bus_out = rd_a;
                SEL_PB:   bus_out = rd_b;
                SEL_PC:   bus_out = rd_c;
                SEL_CTRL: bus_out = {1'b1, cfg};
            endcase
        end
    end
    assign bus_oe = rd_act;

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pa_oe == 8'h00 && pb_oe == 8'h00 && pc_oe == 8'h00
                        && pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00)) else $error("reset"); // R9
    AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !wr_n && sel == 2'b11 && bus_in[7]) |=>
        (pa_oe == {8{~$past(bus_in[4])}} && pb_oe == {8{~$past(bus_in[1])}}
         && pc_oe == {{4{~$past(bus_in[3])}}, {4{~$past(bus_in[0])}}})) else $error("oe"); // R3
    AST_DEF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !wr_n && sel == 2'b11 && bus_in[7]) |=>
        (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00)) else $error("clear"); // R8
    AST_CMD_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !wr_n && sel == 2'b11 && !bus_in[7]) |=>
        (((pc_out ^ $past(pc_out)) & ~$past(cmd_mask)) == 8'h00
         && (pc_out & $past(cmd_mask)) == ($past(cmd_mask) & {8{$past(bus_in[0])}}))) else $error("cmd"); // R7
    AST_INPUT_READ: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !rd_n && sel == 2'b00 && pa_oe == 8'h00) |-> bus_out == pa_in) else $error("in read"); // R4
    AST_BUS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n) |-> (!bus_oe && bus_out == 8'h00)) else $error("bus idle"); // R1

endmodule

// File: tb/triport_pio_test.sv
module triport_pio_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] sel = 2'b00;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Scoreboard queues: what to watch, expected value, requirement tag
    int    q_kind[$];
    int    q_exp[$];
    string q_req[$];

    localparam int K_BUS = 0, K_BOE = 1, K_PA = 2, K_PB = 3, K_PC = 4,
                   K_PAOE = 5, K_PBOE = 6, K_PCOE = 7;

    triport_pio uut (.*);

    always #10 clk = ~clk;  // 50 MHz

    task automatic expect_sig(input int kind, input int exp, input string req);
        q_kind.push_back(kind);
        q_exp.push_back(exp);
        q_req.push_back(req);
    endtask

    task automatic bus_write(input logic [1:0] s, input logic [7:0] d, input logic csn = 1'b0);
        @(negedge clk);
        cs_n = csn; wr_n = 1'b0; sel = s; bus_in = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic bus_read(input logic [1:0] s, input logic [7:0] exp, input string req);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; sel = s;
        expect_sig(K_BUS, exp, req);
        expect_sig(K_BOE, 1, req);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic expect_ports(input int a, input int b, input int c, input string req);
        expect_sig(K_PA, a, req);
        expect_sig(K_PB, b, req);
        expect_sig(K_PC, c, req);
    endtask

    task automatic expect_oe(input int a, input int b, input int c, input string req);
        expect_sig(K_PAOE, a, req);
        expect_sig(K_PBOE, b, req);
        expect_sig(K_PCOE, c, req);
    endtask

    // Monitor: compare queued expectations mid-low-phase
    initial begin
        forever begin
            @(negedge clk);
            #5;
            while (q_kind.size() > 0) begin
                int k, e, act;
                string r;
                k = q_kind.pop_front();
                e = q_exp.pop_front();
                r = q_req.pop_front();
                case (k)
                    K_BUS:  act = int'(bus_out);
                    K_BOE:  act = int'(bus_oe);
                    K_PA:   act = int'(pa_out);
                    K_PB:   act = int'(pb_out);
                    K_PC:   act = int'(pc_out);
                    K_PAOE: act = int'(pa_oe);
                    K_PBOE: act = int'(pb_oe);
                    default: act = int'(pc_oe);
                endcase
                checks++;
                if (act != e) begin
                    fails++;
                    $display("FAIL %s kind=%0d actual=%02h expected=%02h", r, k, act, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        @(negedge clk);
        expect_oe(0, 0, 0, "R9");
        expect_ports(0, 0, 0, "R9");
        expect_sig(K_BOE, 0, "R1");
        expect_sig(K_BUS, 0, "R1");
        bus_read(2'b11, 8'h9B, "R9");

        // R4: inputs read live pins
        pa_in = 8'h5A;
        bus_read(2'b00, 8'h5A, "R4");
        pa_in = 8'hC3;
        bus_read(2'b00, 8'hC3, "R4");
        pb_in = 8'h17;
        bus_read(2'b01, 8'h17, "R4");

        // R2/R3: all outputs, mode 0
        bus_write(2'b11, 8'h80);
        expect_oe(8'hFF, 8'hFF, 8'hFF, "R3");
        bus_read(2'b11, 8'h80, "R2");

        // R5/R6: latched outputs
        bus_write(2'b00, 8'h3C);
        bus_write(2'b01, 8'hA5);
        bus_write(2'b10, 8'h96);
        expect_ports(8'h3C, 8'hA5, 8'h96, "R6");
        bus_read(2'b00, 8'h3C, "R5");
        bus_read(2'b10, 8'h96, "R5");

        // R7: bit commands on port C
        bus_write(2'b11, 8'h0B);  // bit 5 <- 1
        expect_sig(K_PC, 8'hB6, "R7");
        bus_write(2'b11, 8'h0E);  // bit 7 <- 0
        expect_sig(K_PC, 8'h36, "R7");
        expect_ports(8'h3C, 8'hA5, 8'h36, "R7");
        bus_read(2'b11, 8'h80, "R7");

        // R1: chip select high blocks writes
        bus_write(2'b00, 8'hFF, 1'b1);
        expect_sig(K_PA, 8'h3C, "R1");
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b0; sel = 2'b00;
        expect_sig(K_BOE, 0, "R1");
        expect_sig(K_BUS, 0, "R1");
        @(negedge clk);
        rd_n = 1'b1;

        // R8/R2/R3: A input, C lower input, clears latches
        bus_write(2'b11, 8'h91);
        expect_ports(0, 0, 0, "R8");
        expect_oe(8'h00, 8'hFF, 8'hF0, "R3");
        pc_in = 8'h5A;
        bus_write(2'b10, 8'hC3);
        expect_sig(K_PC, 8'hC3, "R6");
        bus_read(2'b10, 8'hCA, "R4");
        pa_in = 8'h66;
        bus_read(2'b00, 8'h66, "R4");
        bus_read(2'b11, 8'h91, "R2");

        // R10: non-basic mode codes stored, act as mode 0
        bus_write(2'b11, 8'hE4);
        bus_read(2'b11, 8'hE4, "R10");
        expect_oe(8'hFF, 8'hFF, 8'hFF, "R10");
        bus_write(2'b00, 8'h11);
        expect_sig(K_PA, 8'h11, "R10");
        bus_read(2'b00, 8'h11, "R10");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule